// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block looks at the two oldest decoded instructions waiting at the head of an in-order instruction queue. In the same cycle it decides whether both can leave together. The older instruction (slot A) always goes to the primary pipe when it is valid. The younger instruction (slot B) may join it in the secondary pipe only when a fixed set of pairing rules allows it. The block reports which pipes receive an instruction and how many instructions the queue should drop from its head. When B is held back, it becomes slot A on the next cycle and may then pair with the instruction behind it.

The decision is purely combinational. Internally it is a single verdict, chosen from an enumerated set in priority order:

- `V_IDLE`: A is not valid, so nothing issues.
- `V_SOLO`: only A is valid.
- `V_SPLIT_JMP`: A is a jump.
- `V_SPLIT_KIND`: a class conflict; either instruction needs microcode, or B needs a resource found only in the primary pipe.
- `V_SPLIT_RAW`: a read-after-write conflict.
- `V_SPLIT_WAW`: a write-after-write conflict.
- `V_SPLIT_CC`: a condition-code dependence, reached only when the condition-code exception is disabled by parameter.
- `V_PAIR`: both instructions issue.

The transitions between verdicts follow that order: the first rule that fails decides the verdict. The output process maps each verdict to pipe enables and a consume count.

Register conflicts are counted only when the relevant destination is really written, which is marked by a per-slot write flag. An older instruction that writes only the condition codes may pair with a younger conditional jump that reads them.

Top module: `pair_issue_chk`

## Requirements
- R1: When A or B is not simple (needs microcode sequencing), `issue_sec` is 0.
- R2: When B needs a primary-pipe-only resource, `issue_sec` is 0.
- R3: When A is a jump of any kind, `issue_sec` is 0.
- R4: When A writes its destination and that register equals any of B's `NSRC` source fields (source k at bits [k*REG_W +: REG_W] of `b_src`), `issue_sec` is 0.
- R5: When both A and B write a destination and the two destination registers are equal, `issue_sec` is 0.
- R6: A with `a_cc_wr`=1 followed by B with `b_cjump`=1 pairs when no other rule blocks it (default `CC_FUSE`=1).
- R7: When both slots are valid and any of R1 to R5 blocks pairing, the outputs are `issue_pri`=1, `issue_sec`=0 and `take_cnt`=1.
- R8: When both slots are valid and no rule blocks pairing, the outputs are `issue_pri`=1, `issue_sec`=1 and `take_cnt`=2.
- R9: When A is valid and B is not, the outputs are `issue_pri`=1, `issue_sec`=0 and `take_cnt`=1.
- R10: When A is not valid, the outputs are all 0, whatever B holds.
- R11: A destination whose write flag is 0 takes part in no register comparison: it cannot cause R4 or R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_vld | input | 1 | Slot A (older) holds an instruction |
| a_simple | input | 1 | Slot A needs no microcode sequencing |
| a_jump | input | 1 | Slot A is a jump (conditional or not) |
| a_cc_wr | input | 1 | Slot A writes the condition codes |
| a_dst_we | input | 1 | Slot A writes its destination register |
| a_dst | input | REG_W | Slot A destination register |
| b_vld | input | 1 | Slot B (younger) holds an instruction |
| b_simple | input | 1 | Slot B needs no microcode sequencing |
| b_prim_only | input | 1 | Slot B needs a primary-pipe-only resource |
| b_cjump | input | 1 | Slot B is a conditional jump reading the condition codes |
| b_dst_we | input | 1 | Slot B writes its destination register |
| b_dst | input | REG_W | Slot B destination register |
| b_src | input | NSRC*REG_W | Slot B source registers, packed |
| issue_pri | output | 1 | Send slot A to the primary pipe |
| issue_sec | output | 1 | Send slot B to the secondary pipe |
| take_cnt | output | 2 | Number of instructions consumed from the queue head |

## Verification
The bench builds the block with `REG_W`=3, `NSRC`=2 and `CC_FUSE`=1. With only eight register names, randomly generated instruction streams produce frequent destination/source and destination/destination collisions. Those collisions come both with and without the write flags set, so the R4, R5 and R11 cases occur often rather than rarely. A behavioural queue model advances its head by its own expected count. This covers the case where a held-back B instruction becomes the next A and then pairs with its successor.

// File: rtl/pair_pkg.sv
package pair_pkg;

    typedef enum logic [2:0] {
        V_IDLE       = 3'd0,
        V_SOLO       = 3'd1,
        V_SPLIT_JMP  = 3'd2,
        V_SPLIT_KIND = 3'd3,
        V_SPLIT_RAW  = 3'd4,
        V_SPLIT_WAW  = 3'd5,
        V_SPLIT_CC   = 3'd6,
        V_PAIR       = 3'd7
    } verdict_e;

    localparam int TAKE_W = 2;

endpackage

// File: rtl/pair_class.sv
module pair_class (
    input  logic a_simple,
    input  logic a_jump,
    input  logic b_simple,
    input  logic b_prim_only,
    output logic head_ok,
    output logic kind_ok
);

    always_comb begin
        head_ok = !a_jump;
        kind_ok = a_simple && b_simple && !b_prim_only;
    end

    // a_r1_kind_needs_simple: a passing class check implies both are simple
    always_comb begin
        a_r1_kind_needs_simple: assert (!kind_ok || (a_simple && b_simple))
            else $error("R1 class check passed a microcoded instruction");
    end

endmodule

// File: rtl/pair_hazard.sv
module pair_hazard #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                  a_dst_we,
    input  logic [REG_W-1:0]      a_dst,
    input  logic                  b_dst_we,
    input  logic [REG_W-1:0]      b_dst,
    input  logic [NSRC*REG_W-1:0] b_src,
    output logic                  raw,
    output logic                  waw
);

    logic [NSRC-1:0] src_hit;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign src_hit[k] = (b_src[k*REG_W +: REG_W] == a_dst);
    end

    always_comb begin
        raw = a_dst_we && (|src_hit);
        waw = a_dst_we && b_dst_we && (a_dst == b_dst);
    end

    // a_r11_waw_needs_writes: a WAW flag only with both write flags set
    always_comb begin
        a_r11_waw_needs_writes: assert (!waw || (a_dst_we && b_dst_we))
            else $error("R11 WAW flagged without both writes");
        a_r11_raw_needs_write: assert (!raw || a_dst_we)
            else $error("R11 RAW flagged without A write");
    end

endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk
    import pair_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NSRC    = 2,
    parameter bit CC_FUSE = 1'b1
) (
    input  logic                  a_vld,
    input  logic                  a_simple,
    input  logic                  a_jump,
    input  logic                  a_cc_wr,
    input  logic                  a_dst_we,
    input  logic [REG_W-1:0]      a_dst,
    input  logic                  b_vld,
    input  logic                  b_simple,
    input  logic                  b_prim_only,
    input  logic                  b_cjump,
    input  logic                  b_dst_we,
    input  logic [REG_W-1:0]      b_dst,
    input  logic [NSRC*REG_W-1:0] b_src,
    output logic                  issue_pri,
    output logic                  issue_sec,
    output logic [TAKE_W-1:0]     take_cnt
);

    logic     head_ok;
    logic     kind_ok;
    logic     raw;
    logic     waw;
    logic     cc_dep;
    verdict_e verdict;

    pair_class u_class (
        .a_simple    (a_simple),
        .a_jump      (a_jump),
        .b_simple    (b_simple),
        .b_prim_only (b_prim_only),
        .head_ok     (head_ok),
        .kind_ok     (kind_ok)
    );

    pair_hazard #(
        .REG_W (REG_W),
        .NSRC  (NSRC)
    ) u_hazard (
        .a_dst_we (a_dst_we),
        .a_dst    (a_dst),
        .b_dst_we (b_dst_we),
        .b_dst    (b_dst),
        .b_src    (b_src),
        .raw      (raw),
        .waw      (waw)
    );

    assign cc_dep = a_cc_wr && b_cjump;

    // Verdict selection: first failing rule wins.
    always_comb begin
        if (!a_vld)                  verdict = V_IDLE;
        else if (!b_vld)             verdict = V_SOLO;
        else if (!head_ok)           verdict = V_SPLIT_JMP;
        else if (!kind_ok)           verdict = V_SPLIT_KIND;
        else if (raw)                verdict = V_SPLIT_RAW;
        else if (waw)                verdict = V_SPLIT_WAW;
        else if (cc_dep && !CC_FUSE) verdict = V_SPLIT_CC;
        else                         verdict = V_PAIR;
    end

    // Output mapping per verdict.
    always_comb begin
        issue_pri = 1'b0;
        issue_sec = 1'b0;
        take_cnt  = '0;
        unique case (verdict)
            V_IDLE: begin
                take_cnt = '0;
            end
            V_SOLO, V_SPLIT_JMP, V_SPLIT_KIND,
            V_SPLIT_RAW, V_SPLIT_WAW, V_SPLIT_CC: begin
                issue_pri = 1'b1;
                take_cnt  = TAKE_W'(1);
            end
            V_PAIR: begin
                issue_pri = 1'b1;
                issue_sec = 1'b1;
                take_cnt  = TAKE_W'(2);
            end
            default: begin
                take_cnt = '0;
            end
        endcase
    end

    always_comb begin
        a_r1_sec_needs_simple: assert (!issue_sec || (a_simple && b_simple))
            else $error("R1 microcoded instruction paired");
        a_r2_sec_not_prim_only: assert (!issue_sec || !b_prim_only)
            else $error("R2 primary-only instruction in secondary pipe");
        a_r3_no_jump_head: assert (!issue_sec || !a_jump)
            else $error("R3 jump paired as first instruction");
        a_r8_two_means_both: assert ((take_cnt != TAKE_W'(2)) || (issue_pri && issue_sec))
            else $error("R8 count two without both pipes");
        a_r10_idle_no_issue: assert (a_vld || (!issue_pri && !issue_sec && take_cnt == '0))
            else $error("R10 issue without valid head");
    end

endmodule

// File: tb/pair_issue_chk_tb_top.sv
module pair_issue_chk_tb_top;

    localparam int REG_W = 3;
    localparam int NSRC  = 2;
    localparam int QN    = 400;

    typedef struct packed {
        logic             vld;
        logic             simple;
        logic             prim;
        logic             jump;
        logic             cjump;
        logic             ccw;
        logic             dwe;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] s1;
        logic [REG_W-1:0] s0;
    } ins_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                  a_vld, a_simple, a_jump, a_cc_wr, a_dst_we;
    logic [REG_W-1:0]      a_dst;
    logic                  b_vld, b_simple, b_prim_only, b_cjump, b_dst_we;
    logic [REG_W-1:0]      b_dst;
    logic [NSRC*REG_W-1:0] b_src;
    logic                  issue_pri, issue_sec;
    logic [1:0]            take_cnt;

    int total = 0;
    int bad   = 0;

    pair_issue_chk #(.REG_W(REG_W), .NSRC(NSRC), .CC_FUSE(1'b1)) dut_i (
        .a_vld(a_vld), .a_simple(a_simple), .a_jump(a_jump), .a_cc_wr(a_cc_wr),
        .a_dst_we(a_dst_we), .a_dst(a_dst),
        .b_vld(b_vld), .b_simple(b_simple), .b_prim_only(b_prim_only),
        .b_cjump(b_cjump), .b_dst_we(b_dst_we), .b_dst(b_dst), .b_src(b_src),
        .issue_pri(issue_pri), .issue_sec(issue_sec), .take_cnt(take_cnt)
    );

    function automatic ins_t mk(bit v, bit s, bit p, bit j, bit cj, bit cc,
                                bit we, int d, int x0, int x1);
        ins_t r;
        r.vld = v; r.simple = s; r.prim = p; r.jump = j | cj; r.cjump = cj;
        r.ccw = cc; r.dwe = we; r.dst = REG_W'(d); r.s0 = REG_W'(x0); r.s1 = REG_W'(x1);
        return r;
    endfunction

    // Behavioural expectation: returns consumed count and the deciding rule tag.
    function automatic int model(ins_t a, ins_t b, output string tag);
        if (!a.vld) begin tag = "R10"; return 0; end
        if (!b.vld) begin tag = "R9"; return 1; end
        if (a.jump) begin tag = "R3"; return 1; end
        if (!a.simple || !b.simple) begin tag = "R1"; return 1; end
        if (b.prim) begin tag = "R2"; return 1; end
        if (a.dwe && (a.dst == b.s0 || a.dst == b.s1)) begin tag = "R4"; return 1; end
        if (a.dwe && b.dwe && a.dst == b.dst) begin tag = "R5"; return 1; end
        if (a.ccw && b.cjump) tag = "R6";
        else tag = "R8";
        return 2;
    endfunction

    task automatic drive(ins_t a, ins_t b);
        a_vld = a.vld; a_simple = a.simple; a_jump = a.jump; a_cc_wr = a.ccw;
        a_dst_we = a.dwe; a_dst = a.dst;
        b_vld = b.vld; b_simple = b.simple; b_prim_only = b.prim; b_cjump = b.cjump;
        b_dst_we = b.dwe; b_dst = b.dst; b_src = {b.s1, b.s0};
    endtask

    task automatic check(ins_t a, ins_t b, string note, output int got);
        string tag;
        int    exp_n;
        logic  exp_p, exp_s;
        @(negedge clk);
        drive(a, b);
        #2;
        exp_n = model(a, b, tag);
        exp_p = (exp_n != 0);
        exp_s = (exp_n == 2);
        total++;
        if (issue_pri !== exp_p || issue_sec !== exp_s || take_cnt !== 2'(exp_n)) begin
            bad++;
            $display("FAIL %s (%s): pri=%0b sec=%0b cnt=%0d expected pri=%0b sec=%0b cnt=%0d",
                     tag, note, issue_pri, issue_sec, take_cnt, exp_p, exp_s, exp_n);
        end
        got = int'(take_cnt);
    endtask

    ins_t q[QN];

    initial begin : watchdog
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        ins_t nul, alu, t1, t2;
        int   g;
        int   head;
        nul = mk(0,0,0,0,0,0,0,0,0,0);
        alu = mk(1,1,0,0,0,0,1,1,2,3);
        drive(nul, nul);
        // R10: idle, and B alone without a head
        check(nul, nul, "R10 nothing valid", g);
        check(nul, mk(1,1,0,0,0,0,1,4,5,6), "R10 B valid without A", g);
        // R9: head alone
        check(alu, nul, "R9 solo", g);
        // R8: independent simple pair
        check(alu, mk(1,1,0,0,0,0,1,4,5,6), "R8 clean pair", g);
        // R1: microcoded in either slot
        check(mk(1,0,0,0,0,0,1,1,2,3), mk(1,1,0,0,0,0,1,4,5,6), "R1 A microcoded", g);
        check(alu, mk(1,0,0,0,0,0,1,4,5,6), "R1 B microcoded", g);
        // R2: B primary-only; A primary-only is fine
        check(alu, mk(1,1,1,0,0,0,1,4,5,6), "R2 B primary-only", g);
        check(mk(1,1,1,0,0,0,1,1,2,3), mk(1,1,0,0,0,0,1,4,5,6), "R8 A primary-only pairs", g);
        // R3: A jump, A conditional jump; B jump is allowed
        check(mk(1,1,0,1,0,0,0,0,0,0), mk(1,1,0,0,0,0,1,4,5,6), "R3 A jump", g);
        check(mk(1,1,0,0,1,0,0,0,0,0), mk(1,1,0,0,0,0,1,4,5,6), "R3 A cond jump", g);
        check(alu, mk(1,1,0,1,0,0,0,0,5,6), "R8 B jump pairs", g);
        // R4: dependence through each source field
        check(alu, mk(1,1,0,0,0,0,1,4,1,6), "R4 src0 match", g);
        check(alu, mk(1,1,0,0,0,0,1,4,5,1), "R4 src1 match", g);
        // R5: same destination
        check(alu, mk(1,1,0,0,0,0,1,1,5,6), "R5 dst match", g);
        // R11: no write flag removes the conflict
        check(mk(1,1,0,0,0,0,0,1,2,3), mk(1,1,0,0,0,0,1,4,1,6), "R11 A no write src match", g);
        check(alu, mk(1,1,0,0,0,0,0,1,5,6), "R11 B no write dst match", g);
        // R6: condition-code setter then conditional jump
        check(mk(1,1,0,0,0,1,0,0,2,3), mk(1,1,0,0,1,0,0,0,5,6), "R6 cc then cjump", g);
        check(mk(1,1,0,0,0,1,1,2,2,3), mk(1,1,0,0,1,0,0,0,2,6), "R6 cc plus R4 dep", g);
        // R7: a split followed by the held instruction pairing with the next
        t1 = alu; t2 = mk(1,1,0,0,0,0,1,4,1,6);
        check(t1, t2, "R7 split first", g);
        check(t2, mk(1,1,0,0,0,0,1,7,5,6), "R7 held pairs next", g);

        // Random queue stream, head advanced by the model's own count.
        for (int i = 0; i < QN; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            q[i] = mk(1, r[0] | r[1] | r[2], (r[3:5] == 3'b000), (r[6:8] == 3'b000),
                      (r[6:8] == 3'b001), r[9], r[10] | r[11],
                      int'($urandom_range(0,7)), int'($urandom_range(0,7)),
                      int'($urandom_range(0,7)));
        end
        head = 0;
        while (head < QN) begin
            ins_t a, b;
            string tg;
            int    n;
            a = q[head];
            b = (head + 1 < QN) ? q[head+1] : nul;
            n = model(a, b, tg);
            check(a, b, "random stream R1 R2 R3 R4 R5 R6 R7 R8 R9 R11", g);
            head += n;
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule